// File: doc/BRIEF.md
# Microwire Serial Memory Host Controller

This block is the host side of a Microwire link to a byte-organised serial memory. A command arrives on a valid/ready request port and carries an operation code, an 8-bit address and 8 bits of write data. The controller keeps chip select low for a programmable guard time. It then raises chip select and toggles the serial clock from the system clock, with a programmable half period. While it does so it sends a start bit, a 2-bit opcode, a 9-bit address field and, where the command has one, a data byte. A read also collects the returned byte from the data-out line.

Erase and write commands start a self-timed operation in the memory. For these the controller lowers chip select, waits the guard time again, then raises chip select and watches the data-out line. A low level means busy and a high level means ready. The command finishes when ready is seen, or when a programmable number of system clocks has passed, in which case a timeout flag is raised. Every command ends with a one-cycle `done` pulse. The read result and the timeout flag are valid in that cycle.

Back-pressure rule: `req_ready` is high only while the controller is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. A requester must hold its fields stable until that cycle. While the controller is busy, `req_valid` is simply ignored.

Top module: `mw_eeprom_host`

## Requirements
- R1: A frame is sent most significant bit first as a start bit 1, a 2-bit opcode, then a 9-bit address field: one don't-care bit sent as 0, followed by A7..A0. The `req_op` codes are 0 read (opcode 10), 1 write (01), 2 erase (11), 3 write-enable, 4 write-disable, 5 erase-all and 6 write-all. Codes 3 to 6 use opcode 00 and put a sub-code in the top two address-field bits: 11 for write-enable, 00 for write-disable, 10 for erase-all, 01 for write-all. Their other seven address bits are sent as 0. Code 7 behaves as code 4.
- R2: Read, write and write-all frames are 20 serial clocks long, and the other commands are 12. Write and write-all append `req_wdata` D7..D0 after the address field. A read drives DI low during its eight data clocks.
- R3: The serial clock rests low, rises only while chip select is high, and holds each level for `cfg_half`+1 system clocks. DI changes only while the serial clock is low.
- R4: Before every rise of chip select, chip select has been low for at least `cfg_gap`+1 system clocks. This applies both before a frame and before a poll.
- R5: On a read, DO is sampled at the end of each low clock phase. The bit after rising edge 12 is a dummy and is discarded. The bits after edges 13..20 form `rsp_rdata` D7..D0, most significant bit first. `rsp_rdata` reads 0 after any other command.
- R6: After an erase, erase-all, write or write-all frame, the controller lowers chip select, waits the guard time, and raises chip select with the serial clock low. When it samples DO high it lowers chip select and pulses `done` with `rsp_timeout` 0. There is exactly one poll window per such command.
- R7: If DO stays low for `cfg_tmo`+1 poll cycles, chip select is lowered and `done` pulses with `rsp_timeout` 1. The next command then runs normally.
- R8: `req_ready` is high after reset and whenever the controller is idle, and low from acceptance until `done`. A `req_valid` seen while `req_ready` is low starts no frame. `done` lasts exactly one cycle.
- R9: Read, write-enable and write-disable commands have no poll window. `done` pulses in the same cycle that chip select falls at the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_op | input | 3 | Command code (see R1) |
| req_addr | input | 8 | Memory address |
| req_wdata | input | 8 | Data for write and write-all |
| cfg_half | input | 8 | Serial clock half period minus one, in system clocks |
| cfg_gap | input | 8 | Chip-select low guard time minus one, in system clocks |
| cfg_tmo | input | 16 | Poll limit minus one, in system clocks |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read result, valid with `done` |
| rsp_timeout | output | 1 | Poll timed out, valid with `done` |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data to the memory |
| mw_do | input | 1 | Serial data and ready/busy from the memory |

## Verification
A wrong bit index or a corrupted shift register appears at once in the DI bit pattern the memory model records. A wrong length counter appears as an edge count other than 12 or 20 when chip select falls, one serial clock after the last correct edge. A divider or guard counter that is off by one shows up in the very next phase as a high run or low-gap width that differs from `cfg_half`+1 or falls short of `cfg_gap`+1. Mistakes in poll or completion sequencing show within one command as a missing or extra poll window, a wrong timeout flag or a `done` that lasts more than one cycle.

// File: rtl/mw_host_pkg.sv
package mw_host_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int HDR_W   = 3 + 1 + ADDR_W;   // start + opcode + address field
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    CMD_READ      = 3'd0,
    CMD_WRITE     = 3'd1,
    CMD_ERASE     = 3'd2,
    CMD_WREN      = 3'd3,
    CMD_WRDIS     = 3'd4,
    CMD_ERASE_ALL = 3'd5,
    CMD_WRITE_ALL = 3'd6
  } mw_cmd_e;
endpackage

// File: rtl/mw_frame_build.sv
module mw_frame_build
  import mw_host_pkg::*;
(
  input  logic [2:0]         op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len,
  output logic               is_read,
  output logic               is_prog
);
  localparam int PAD_W = ADDR_W - 1;

  logic [1:0]        opc;
  logic [ADDR_W:0]   afield;
  logic              long_f;

  always_comb begin
    opc     = 2'b00;
    afield  = '0;
    long_f  = 1'b0;
    is_read = 1'b0;
    is_prog = 1'b0;
    case (op)
      CMD_READ:      begin opc = 2'b10; afield = {1'b0, addr}; long_f = 1'b1; is_read = 1'b1; end
      CMD_WRITE:     begin opc = 2'b01; afield = {1'b0, addr}; long_f = 1'b1; is_prog = 1'b1; end
      CMD_ERASE:     begin opc = 2'b11; afield = {1'b0, addr}; is_prog = 1'b1; end
      CMD_WREN:      afield = {2'b11, {PAD_W{1'b0}}};
      CMD_ERASE_ALL: begin afield = {2'b10, {PAD_W{1'b0}}}; is_prog = 1'b1; end
      CMD_WRITE_ALL: begin afield = {2'b01, {PAD_W{1'b0}}}; long_f = 1'b1; is_prog = 1'b1; end
      default:       afield = {2'b00, {PAD_W{1'b0}}};
    endcase
  end

  assign frame = {1'b1, opc, afield, (long_f && !is_read) ? wdata : {DATA_W{1'b0}}};
  assign len   = long_f ? LEN_W'(FRAME_W) : LEN_W'(HDR_W);
endmodule

// File: rtl/mw_sk_divider.sv
module mw_sk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_rx_capture.sv
module mw_rx_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         take,
  input  logic         din,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n)     data <= '0;
    else if (clear) data <= '0;
    else if (take)  data <= {data[W-2:0], din};
  end
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_host_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8,
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [TMO_W-1:0]  cfg_tmo,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int CNT_W    = (TMO_W > GAP_W) ? TMO_W : GAP_W;
  localparam int RD_FIRST = HDR_W + 1;
  localparam int RD_LAST  = FRAME_W;

  typedef enum logic [2:0] {ST_IDLE, ST_GAP, ST_SHIFT, ST_GAP2, ST_POLL} st_e;

  st_e                st_q;
  logic [FRAME_W-1:0] frm_d, frm_q;
  logic [LEN_W-1:0]   len_d, len_q, idx_q;
  logic               rd_d, rd_q, pg_d, pg_q, hi_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tick, accept, cap_en;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  mw_frame_build u_frame (
    .op(req_op), .addr(req_addr), .wdata(req_wdata),
    .frame(frm_d), .len(len_d), .is_read(rd_d), .is_prog(pg_d)
  );

  mw_sk_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_SHIFT), .half(cfg_half), .tick(tick)
  );

  assign cap_en = (st_q == ST_SHIFT) && tick && !hi_q && rd_q &&
                  (idx_q >= LEN_W'(RD_FIRST)) && (idx_q <= LEN_W'(RD_LAST));

  mw_rx_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(accept), .take(cap_en), .din(mw_do), .data(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      frm_q       <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      rd_q        <= 1'b0;
      pg_q        <= 1'b0;
      hi_q        <= 1'b0;
      cnt_q       <= '0;
      done        <= 1'b0;
      rsp_timeout <= 1'b0;
      mw_cs       <= 1'b0;
      mw_sk       <= 1'b0;
      mw_di       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          frm_q       <= frm_d;
          len_q       <= len_d;
          rd_q        <= rd_d;
          pg_q        <= pg_d;
          cnt_q       <= '0;
          rsp_timeout <= 1'b0;
          st_q        <= ST_GAP;
        end
        ST_GAP: if (cnt_q == CNT_W'(cfg_gap)) begin
          mw_cs <= 1'b1;
          mw_sk <= 1'b0;
          hi_q  <= 1'b0;
          idx_q <= '0;
          mw_di <= frm_q[FRAME_W-1];
          st_q  <= ST_SHIFT;
        end else cnt_q <= cnt_q + 1'b1;
        ST_SHIFT: if (tick) begin
          if (!hi_q) begin
            if (idx_q == len_q) begin
              mw_cs <= 1'b0;
              mw_di <= 1'b0;
              cnt_q <= '0;
              if (pg_q) st_q <= ST_GAP2;
              else begin
                done <= 1'b1;
                st_q <= ST_IDLE;
              end
            end else begin
              mw_sk <= 1'b1;
              hi_q  <= 1'b1;
            end
          end else begin
            mw_sk <= 1'b0;
            hi_q  <= 1'b0;
            idx_q <= idx_q + 1'b1;
            frm_q <= frm_q << 1;
            mw_di <= frm_q[FRAME_W-2];
          end
        end
        ST_GAP2: if (cnt_q == CNT_W'(cfg_gap)) begin
          mw_cs <= 1'b1;
          cnt_q <= '0;
          st_q  <= ST_POLL;
        end else cnt_q <= cnt_q + 1'b1;
        ST_POLL: if (mw_do || cnt_q == CNT_W'(cfg_tmo)) begin
          mw_cs       <= 1'b0;
          done        <= 1'b1;
          rsp_timeout <= !mw_do;
          st_q        <= ST_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- checker support and assertions ----------------
  logic [GAP_W:0]   low_run;
  logic [LEN_W-1:0] edge_cnt;
  logic             sk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      edge_cnt <= '0;
      sk_d     <= 1'b0;
    end else begin
      sk_d <= mw_sk;
      if (mw_cs) low_run <= '0;
      else if (low_run != '1) low_run <= low_run + 1'b1;
      if (!mw_cs) edge_cnt <= '0;
      else if (mw_sk && !sk_d) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  // R3
  sk_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_sk |-> mw_cs);

  // R3
  di_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk && sk_d) |-> $stable(mw_di));

  // R4
  cs_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_cs) |-> (low_run > {1'b0, cfg_gap}));

  // R2
  frame_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_cs) |-> (edge_cnt == '0 || edge_cnt == LEN_W'(HDR_W) || edge_cnt == LEN_W'(FRAME_W)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

// File: tb/mw_eeprom_host_bench.sv
`timescale 1ns/1ps
module mw_eeprom_host_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [7:0]  req_addr = 8'h00;
  logic [7:0]  req_wdata = 8'h00;
  logic [7:0]  cfg_half = 8'd0;
  logic [7:0]  cfg_gap = 8'd0;
  logic [15:0] cfg_tmo = 16'd50;
  logic        done, rsp_timeout, mw_cs, mw_sk, mw_di, mw_do;
  logic [7:0]  rsp_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  mw_eeprom_host u_mw_eeprom_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_half(cfg_half), .cfg_gap(cfg_gap), .cfg_tmo(cfg_tmo),
    .done(done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
  );

  // ---------------- memory model (all state updated here) ----------------
  logic        clr = 1'b0;
  logic [7:0]  rd_byte = 8'h00;
  int          busy_n = 0;
  logic        sk_p = 0, cs_p = 0, di_p = 0, do_q = 0, in_poll = 0, frame_seen = 0;
  int          ecnt = 0, poll_cyc = 0, win_len = 0, frames = 0, polls = 0, last_len = 0;
  logic [31:0] rx = 0, last_rx = 0;
  int          hi_run = 0, lo_run = 0, hi_bad = 0, gap_bad = 0, di_bad = 0;

  assign mw_do = in_poll ? (poll_cyc >= busy_n) : do_q;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    sk_p    <= mw_sk;
    cs_p    <= mw_cs;
    di_p    <= mw_di;
    win_len <= mw_cs ? win_len + 1 : 0;
    if (clr) begin
      frame_seen <= 0; frames <= 0; polls <= 0;
      hi_bad <= 0; gap_bad <= 0; di_bad <= 0;
    end else begin
      if (mw_cs && !cs_p) begin
        ecnt <= 0; rx <= 0; in_poll <= frame_seen; poll_cyc <= 0;
      end else if (mw_cs && mw_sk && !sk_p) begin
        ecnt <= ecnt + 1;
        rx   <= {rx[30:0], mw_di};
        if (ecnt + 1 == 12) do_q <= 1'b0;
        else if (ecnt + 1 >= 13 && ecnt + 1 <= 20) do_q <= rd_byte[19-ecnt];
      end
      if (in_poll && mw_cs) poll_cyc <= poll_cyc + 1;
      if (!mw_cs && cs_p) begin
        do_q    <= 1'b0;
        in_poll <= 1'b0;
        if (in_poll) polls <= polls + 1;
        else begin
          frames <= frames + 1; last_rx <= rx; last_len <= ecnt; frame_seen <= 1;
        end
      end
      if (mw_sk) hi_run <= hi_run + 1;
      else if (hi_run != 0) begin
        if (hi_run != cfg_half + 1) hi_bad <= hi_bad + 1;
        hi_run <= 0;
      end
      if (!mw_cs) lo_run <= lo_run + 1;
      else if (lo_run != 0) begin
        if (lo_run < cfg_gap + 1) gap_bad <= gap_bad + 1;
        lo_run <= 0;
      end
      if (mw_sk && sk_p && mw_di != di_p) di_bad <= di_bad + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_bits(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
    case (op)
      3'd0:    return {1'b1, 2'b10, 1'b0, a, 8'h00};
      3'd1:    return {1'b1, 2'b01, 1'b0, a, d};
      3'd2:    return {8'h00, 1'b1, 2'b11, 1'b0, a};
      3'd3:    return {8'h00, 1'b1, 2'b00, 2'b11, 7'b0};
      3'd5:    return {8'h00, 1'b1, 2'b00, 2'b10, 7'b0};
      3'd6:    return {1'b1, 2'b00, 2'b01, 7'b0, d};
      default: return {8'h00, 1'b1, 2'b00, 2'b00, 7'b0};
    endcase
  endfunction

  function automatic int exp_len(input logic [2:0] op);
    return (op == 3'd0 || op == 3'd1 || op == 3'd6) ? 20 : 12;
  endfunction

  function automatic bit is_prog(input logic [2:0] op);
    return (op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6);
  endfunction

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d,
                         input int busy, input bit exp_tmo, input bit stuff);
    int   n;
    logic got_tmo;
    logic [7:0] got_data;
    int   got_win;
    rd_byte = a ^ 8'h5A;
    busy_n  = busy;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    n = 0;
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (stuff) begin
      req_valid = 1'b1; req_op = 3'd3; req_addr = ~a;
      repeat (6) @(negedge clk);
      check(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R8 done reached", done, 1);
    got_tmo  = rsp_timeout;
    got_data = rsp_rdata;
    got_win  = win_len;
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    @(negedge clk);
    check(frames == 1, "R8 exactly one frame", frames, 1);
    check(last_len == exp_len(op), "R2 frame length", last_len, exp_len(op));
    check(last_rx[19:0] == exp_bits(op, a, d), "R1 frame bits", last_rx[19:0], exp_bits(op, a, d));
    if (is_prog(op)) check(polls == 1, "R6 one poll window", polls, 1);
    else             check(polls == 0, "R9 no poll window", polls, 0);
    check(rsp_timeout == exp_tmo && got_tmo == exp_tmo, "R6 R7 timeout flag", got_tmo, exp_tmo);
    if (exp_tmo) check(got_win == cfg_tmo + 1, "R7 poll window length", got_win, cfg_tmo + 1);
    check(got_data == ((op == 3'd0) ? (a ^ 8'h5A) : 8'h00), "R5 read data", got_data,
          (op == 3'd0) ? (a ^ 8'h5A) : 8'h00);
    check(hi_bad == 0 && di_bad == 0, "R3 clock high width and DI hold", hi_bad + di_bad, 0);
    check(gap_bad == 0, "R4 chip select guard", gap_bad, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    wait (cyc >= 190000);
    $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] alist [4];
    alist = '{8'h00, 8'h5A, 8'hFF, 8'h81};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
    check(mw_cs == 1'b0 && mw_sk == 1'b0, "R3 pins idle after reset", {mw_cs, mw_sk}, 0);
    check(done == 1'b0, "R8 no done after reset", done, 0);

    for (int h = 0; h < 2; h++) begin
      for (int g = 0; g < 2; g++) begin
        cfg_half = 8'(h * 2);
        cfg_gap  = 8'(g * 3);
        for (int op = 0; op < 8; op++) begin
          for (int k = 0; k < 4; k++) begin
            run_cmd(3'(op), alist[k], 8'(alist[k] * 3 + op), 4 + op, 1'b0, 1'b0);
          end
        end
      end
    end

    // R7: memory stays busy beyond the poll limit, then a normal command follows
    cfg_half = 8'd1; cfg_gap = 8'd2; cfg_tmo = 16'd20;
    run_cmd(3'd1, 8'h3C, 8'hC3, 100000, 1'b1, 1'b0);
    run_cmd(3'd2, 8'h11, 8'h00, 3, 1'b0, 1'b0);
    run_cmd(3'd0, 8'hA7, 8'h00, 0, 1'b0, 1'b0);

    // R8: a request held while busy is ignored
    cfg_tmo = 16'd50;
    run_cmd(3'd0, 8'h96, 8'h00, 0, 1'b0, 1'b1);
    run_cmd(3'd6, 8'h00, 8'hE1, 6, 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule